// File: doc/BRIEF.md
# MDIO Management Slave Register File

This block is the PHY-side endpoint of the two-wire management bus. It watches a slow management clock (MDC) and a shared bidirectional data line (MDIO, split here into an input, an output and an output enable), recognises framed read and write transactions, and answers only those that carry its own 5-bit PHY address. Read data is driven back over the shared line after a two-bit bus turnaround. Write data lands in a small set of registers.

The registers cover the basic control, status, identifier and ability words (addresses 0 to 6) and a handful of vendor words (16, 17, 18, 21 to 24). Three bits reach the rest of the PHY as plain pins: a power-down request, an enable for automatic cable-detect power reduction, and a maskable interrupt. MDC and MDIO arrive asynchronously and are synchronised into the system clock domain. The pad itself and the functions the control bits steer are outside this block.

A frame is 64 MDC periods: 32 one bits of preamble, start pair 0 then 1, a 2-bit opcode (10 read, 01 write), PHY address then register address (5 bits each, MSB first), a 2-bit turnaround, then 16 data bits sent MSB first.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: After reset pwr_down is 0, auto_pd_en is 1, irq is 0, mdio_oe is 0, and register 0 reads 0x3100.
- R2: A write frame with a matching PHY address stores the 16 data bits, and a later read of the same register returns them (register 4 and vendor register 22 are read/write).
- R3: A frame whose PHY address differs from phy_addr is ignored: mdio_oe stays 0 for the whole frame and a write leaves the register unchanged.
- R4: A frame must follow at least 32 consecutive one bits. With only 31 ones before the start pair, the frame is ignored and a write has no effect.
- R5: During a matching read, the slave leaves MDIO released for the first turnaround bit, drives 0 for the second, then drives the 16 data bits MSB first.
- R6: Register 0 bit 11 drives pwr_down. While it is 1, management reads and writes still work.
- R7: Register 16 bit 4 drives auto_pd_en. It resets to 1, and writing 0 there clears the pin.
- R8: Writing 1 to register 0 bit 15 returns all writable registers to their reset values, and bit 15 reads back as 0.
- R9: A read of an unimplemented address (for example 7 or 30) returns 0, and a write to one changes nothing.
- R10: Register 21 holds pending interrupt flags in bits 3:0 and mask bits in bits 11:8, where 1 means masked. A pulse on int_event[n] sets pending bit n. irq is 1 while any pending bit is unmasked. A read of register 21 clears the pending bits. Writes change only the mask bits.
- R11: Registers 2 and 3 return the identifier parameters (0x0181, 0xB8A0) and ignore writes. Register 1 reads 0x7849 with bit 2 equal to link_up. Register 5 returns lp_ability.
- R12: MDIO is released again after the last data bit of a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| phy_addr | input | 5 | This slave's bus address |
| mdc | input | 1 | Management clock, asynchronous |
| mdio_i | input | 1 | Sensed level of the shared data line |
| mdio_o | output | 1 | Value driven onto the data line |
| mdio_oe | output | 1 | Drive enable for the data line |
| link_up | input | 1 | Link state shown in register 1 bit 2 |
| lp_ability | input | 16 | Partner ability word shown in register 5 |
| int_event | input | 4 | One-cycle interrupt event pulses |
| pwr_down | output | 1 | Power-down request (register 0 bit 11) |
| auto_pd_en | output | 1 | Automatic power reduction enable (register 16 bit 4) |
| irq | output | 1 | Interrupt, high while an unmasked flag is pending |

## Verification
After an MDC rising edge, mdio_o and mdio_oe change about three system clocks later: two synchroniser stages plus the edge-detect register. The bench therefore samples the line at the end of each MDC low phase, eight clocks after the fall and just before the next rise. Register side effects appear on pwr_down and auto_pd_en about four clocks after the MDC rise that carries the final data bit. The bench checks these pins only after one more idle MDC period of sixteen clocks. irq follows an event pulse two clocks later, and the bench waits three clocks before looking at it.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int DW = 16;
  localparam int AW = 5;
  localparam logic [1:0] OP_RD = 2'b10;
  localparam logic [1:0] OP_WR = 2'b01;

  localparam logic [AW-1:0] A_CTRL = 5'd0;
  localparam logic [AW-1:0] A_STAT = 5'd1;
  localparam logic [AW-1:0] A_ID1  = 5'd2;
  localparam logic [AW-1:0] A_ID2  = 5'd3;
  localparam logic [AW-1:0] A_ADV  = 5'd4;
  localparam logic [AW-1:0] A_LPA  = 5'd5;
  localparam logic [AW-1:0] A_EXP  = 5'd6;
  localparam logic [AW-1:0] A_VCFG = 5'd16;
  localparam logic [AW-1:0] A_INT  = 5'd21;

  typedef enum logic [2:0] {
    FS_PRE, FS_ST, FS_OP, FS_ADDR, FS_TA, FS_DATA
  } frame_st_t;

  typedef struct packed {
    logic          wr;
    logic          rd;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
  } mgmt_req_t;
endpackage

// File: rtl/mdio_sync.sv
module mdio_sync #(
  parameter int WIDTH = 2,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= RST_VAL;
        else if (s == 0) stg[s] <= d;
        else stg[s] <= stg[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/mdio_frame_ctl.sv
module mdio_frame_ctl
  import mdio_mgmt_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          bit_in,
  input  logic [AW-1:0] phy_addr,
  input  logic [DW-1:0] rd_data,
  output mgmt_req_t     req,
  output logic          mdio_o,
  output logic          mdio_oe
);
  localparam int CW = ($clog2(PRE_LEN+1) > 5) ? $clog2(PRE_LEN+1) : 5;
  localparam logic [CW-1:0] PRE_FULL = CW'(PRE_LEN);
  localparam logic [CW-1:0] ADDR_LAST = CW'(2*AW-1);
  localparam logic [CW-1:0] DATA_LAST = CW'(DW-1);

  frame_st_t       st;
  logic [CW-1:0]   cnt;
  logic [1:0]      op_q;
  logic [2*AW-1:0] addr_sh;
  logic [DW-1:0]   dsh;
  logic            match;
  logic [1:0]      opn;
  logic [2*AW-1:0] addrn;

  assign opn   = {op_q[0], bit_in};
  assign addrn = {addr_sh[2*AW-2:0], bit_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= FS_PRE;
      cnt     <= '0;
      op_q    <= '0;
      addr_sh <= '0;
      dsh     <= '0;
      match   <= 1'b0;
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
      req     <= '0;
    end else begin
      req.wr <= 1'b0;
      req.rd <= 1'b0;
      if (tick) begin
        unique case (st)
          FS_PRE: begin
            mdio_oe <= 1'b0;
            if (bit_in) begin
              if (cnt != PRE_FULL) cnt <= cnt + 1'b1;
            end else begin
              if (cnt == PRE_FULL) st <= FS_ST;
              cnt <= '0;
            end
          end
          FS_ST: begin
            st <= bit_in ? FS_OP : FS_PRE;
            cnt <= '0;
          end
          FS_OP: begin
            op_q <= opn;
            if (cnt == CW'(1)) begin
              cnt <= '0;
              st  <= (opn == OP_RD || opn == OP_WR) ? FS_ADDR : FS_PRE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          FS_ADDR: begin
            addr_sh <= addrn;
            if (cnt == ADDR_LAST) begin
              cnt      <= '0;
              st       <= FS_TA;
              match    <= (addrn[2*AW-1:AW] == phy_addr);
              req.addr <= addrn[AW-1:0];
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          FS_TA: begin
            if (cnt == '0) begin
              cnt <= CW'(1);
              if (match && op_q == OP_RD) begin
                mdio_oe <= 1'b1;
                mdio_o  <= 1'b0;
                dsh     <= rd_data;
                req.rd  <= 1'b1;
              end
            end else begin
              cnt <= '0;
              st  <= FS_DATA;
              if (match && op_q == OP_RD) begin
                mdio_o <= dsh[DW-1];
                dsh    <= {dsh[DW-2:0], 1'b0};
              end
            end
          end
          FS_DATA: begin
            dsh    <= {dsh[DW-2:0], bit_in};
            mdio_o <= dsh[DW-1];
            if (cnt == DATA_LAST) begin
              cnt     <= '0;
              st      <= FS_PRE;
              mdio_oe <= 1'b0;
              if (match && op_q == OP_WR) begin
                req.wr    <= 1'b1;
                req.wdata <= {dsh[DW-2:0], bit_in};
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: st <= FS_PRE;
        endcase
      end
    end
  end

  // R5: the first driven bit of any read is the turnaround zero
  a_r5_ta_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdio_oe) |-> !mdio_o);
  // R3: never drive the line for a foreign address
  a_r3_quiet_foreign: assert property (@(posedge clk) disable iff (!rst_n)
    !match |-> !mdio_oe);
  // R12: line released while hunting for a preamble
  a_r12_release_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (st == FS_PRE) |-> !mdio_oe);
  // R2: a frame yields at most one register access per cycle
  a_r2_single_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req.wr, req.rd}));
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_mgmt_pkg::*;
#(
  parameter int INT_W = 4,
  parameter logic [DW-1:0] PHY_ID1 = 16'h0181,
  parameter logic [DW-1:0] PHY_ID2 = 16'hB8A0,
  parameter logic [DW-1:0] STATUS_CAPS = 16'h7849,
  parameter logic [DW-1:0] CTRL_RST = 16'h3100,
  parameter logic [DW-1:0] ADV_RST = 16'h01E1,
  parameter logic [DW-1:0] VCFG_RST = 16'h0010
) (
  input  logic             clk,
  input  logic             rst_n,
  input  mgmt_req_t        req,
  input  logic             link_up,
  input  logic [DW-1:0]    lp_ability,
  input  logic [INT_W-1:0] int_event,
  output logic [DW-1:0]    rd_data,
  output logic             pwr_down,
  output logic             auto_pd_en,
  output logic             irq
);
  localparam int NSCR = 5;
  localparam logic [AW-1:0] SCR_ADDR [NSCR] = '{5'd17, 5'd18, 5'd22, 5'd23, 5'd24};

  logic [DW-1:0]    ctrl, adv, vcfg;
  logic [DW-1:0]    scr [NSCR];
  logic [INT_W-1:0] mask, pend;
  logic             sreset;
  logic [DW-1:0]    int_word;

  assign sreset = req.wr && req.addr == A_CTRL && req.wdata[15];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= CTRL_RST;
      adv  <= ADV_RST;
      vcfg <= VCFG_RST;
      mask <= '0;
    end else if (sreset) begin
      ctrl <= CTRL_RST;
      adv  <= ADV_RST;
      vcfg <= VCFG_RST;
      mask <= '0;
    end else if (req.wr) begin
      if (req.addr == A_CTRL) ctrl <= {1'b0, req.wdata[14:0]};
      if (req.addr == A_ADV)  adv  <= req.wdata;
      if (req.addr == A_VCFG) vcfg <= req.wdata;
      if (req.addr == A_INT)  mask <= req.wdata[8 +: INT_W];
    end
  end

  generate
    for (genvar g = 0; g < NSCR; g++) begin : g_scr
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) scr[g] <= '0;
        else if (sreset) scr[g] <= '0;
        else if (req.wr && req.addr == SCR_ADDR[g]) scr[g] <= req.wdata;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      irq  <= 1'b0;
    end else begin
      pend <= ((req.rd && req.addr == A_INT) || sreset ? '0 : pend) | int_event;
      irq  <= |(pend & ~mask);
    end
  end

  always_comb begin
    int_word = '0;
    int_word[INT_W-1:0] = pend;
    int_word[8 +: INT_W] = mask;
  end

  always_comb begin
    rd_data = '0;
    unique case (req.addr)
      A_CTRL: rd_data = {1'b0, ctrl[14:0]};
      A_STAT: rd_data = (STATUS_CAPS & ~16'h0004) | {13'd0, link_up, 2'b00};
      A_ID1:  rd_data = PHY_ID1;
      A_ID2:  rd_data = PHY_ID2;
      A_ADV:  rd_data = adv;
      A_LPA:  rd_data = lp_ability;
      A_EXP:  rd_data = '0;
      A_VCFG: rd_data = vcfg;
      A_INT:  rd_data = int_word;
      default: begin
        for (int k = 0; k < NSCR; k++)
          if (req.addr == SCR_ADDR[k]) rd_data = scr[k];
      end
    endcase
  end

  assign pwr_down   = ctrl[11];
  assign auto_pd_en = vcfg[4];

  // R6: power-down changes only through a register write
  a_r6_pdn_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    !req.wr |=> $stable(pwr_down));
  // R8: soft reset restores the power-down default
  a_r8_sreset_default: assert property (@(posedge clk) disable iff (!rst_n)
    sreset |=> (pwr_down == CTRL_RST[11] && auto_pd_en == VCFG_RST[4]));
  // R10: nothing unmasked pending means no interrupt next cycle
  a_r10_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & ~mask) == '0) |=> !irq);
endmodule

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave
  import mdio_mgmt_pkg::*;
#(
  parameter int INT_W = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    phy_addr,
  input  logic             mdc,
  input  logic             mdio_i,
  output logic             mdio_o,
  output logic             mdio_oe,
  input  logic             link_up,
  input  logic [DW-1:0]    lp_ability,
  input  logic [INT_W-1:0] int_event,
  output logic             pwr_down,
  output logic             auto_pd_en,
  output logic             irq
);
  logic [1:0]    sync_q;
  logic          mdc_d;
  logic          tick;
  mgmt_req_t     req;
  logic [DW-1:0] rd_data;

  mdio_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b10)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({mdio_i, mdc}), .q(sync_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mdc_d <= 1'b0;
    else mdc_d <= sync_q[0];
  end

  assign tick = sync_q[0] && !mdc_d;

  mdio_frame_ctl u_frame (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bit_in(sync_q[1]),
    .phy_addr(phy_addr), .rd_data(rd_data), .req(req),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  mdio_regs #(.INT_W(INT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .req(req), .link_up(link_up),
    .lp_ability(lp_ability), .int_event(int_event), .rd_data(rd_data),
    .pwr_down(pwr_down), .auto_pd_en(auto_pd_en), .irq(irq)
  );
endmodule

// File: tb/mdio_mgmt_slave_bench.sv
module mdio_mgmt_slave_bench;
  localparam int H = 8;
  localparam logic [4:0] MY = 5'h03;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mdc = 1'b0;
  logic m_en = 1'b0, m_val = 1'b1;
  logic link_up = 1'b1;
  logic [15:0] lp_ability = 16'h45E1;
  logic [3:0] int_event = '0;
  logic mdio_o, mdio_oe, pwr_down, auto_pd_en, irq, line;
  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  assign line = mdio_oe ? mdio_o : (m_en ? m_val : 1'b1);

  mdio_mgmt_slave u_mdio_mgmt_slave (
    .clk(clk), .rst_n(rst_n), .phy_addr(MY), .mdc(mdc), .mdio_i(line),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .link_up(link_up),
    .lp_ability(lp_ability), .int_event(int_event), .pwr_down(pwr_down),
    .auto_pd_en(auto_pd_en), .irq(irq)
  );

  task automatic check(input string r, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  // one MDC period; samples line and oe just before the rising edge
  task automatic mbit(input logic en, input logic v, output logic seen, output logic oe);
    @(negedge clk);
    m_en = en; m_val = v; mdc = 1'b0;
    repeat (H) @(negedge clk);
    seen = line; oe = mdio_oe;
    mdc = 1'b1;
    repeat (H) @(negedge clk);
    mdc = 1'b0;
  endtask

  logic       ta1_oe, ta2_oe, ta2_v, any_oe, end_oe;

  task automatic frame(input int pre, input logic [1:0] op, input logic [4:0] pa,
                       input logic [4:0] ra, input logic [15:0] wd, output logic [15:0] rd);
    logic s, o;
    logic [13:0] hdr;
    hdr = {2'b01, op, pa, ra};
    any_oe = 1'b0;
    mbit(1'b1, 1'b0, s, o);
    for (int i = 0; i < pre; i++) begin mbit(1'b1, 1'b1, s, o); any_oe |= o; end
    for (int i = 13; i >= 0; i--) begin mbit(1'b1, hdr[i], s, o); any_oe |= o; end
    if (op == 2'b10) begin
      mbit(1'b0, 1'b1, s, ta1_oe); any_oe |= ta1_oe;
      mbit(1'b0, 1'b1, ta2_v, ta2_oe); any_oe |= ta2_oe;
      for (int i = 15; i >= 0; i--) begin mbit(1'b0, 1'b1, rd[i], o); any_oe |= o; end
    end else begin
      mbit(1'b1, 1'b1, s, o); mbit(1'b1, 1'b0, s, o);
      for (int i = 15; i >= 0; i--) mbit(1'b1, wd[i], s, o);
      rd = '0;
    end
    mbit(1'b1, 1'b1, s, end_oe);
  endtask

  task automatic wr(input logic [4:0] ra, input logic [15:0] d);
    logic [15:0] x;
    frame(32, 2'b01, MY, ra, d, x);
  endtask

  task automatic rdr(input logic [4:0] ra, output logic [15:0] d);
    frame(32, 2'b10, MY, ra, 16'h0, d);
  endtask

  task automatic pulse(input logic [3:0] e);
    @(negedge clk); int_event = e;
    @(negedge clk); int_event = '0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [15:0] d;
    check("R1 pwr_down", {15'd0, pwr_down}, 16'd0);
    check("R1 auto_pd_en", {15'd0, auto_pd_en}, 16'd1);
    check("R1 irq", {15'd0, irq}, 16'd0);
    check("R1 oe", {15'd0, mdio_oe}, 16'd0);
    rdr(5'd0, d); check("R1 reg0", d, 16'h3100);
  endtask

  task automatic t_rw;
    logic [15:0] d;
    wr(5'd4, 16'h05E1); rdr(5'd4, d); check("R2 reg4", d, 16'h05E1);
    check("R5 ta1 released", {15'd0, ta1_oe}, 16'd0);
    check("R5 ta2 driven", {15'd0, ta2_oe}, 16'd1);
    check("R5 ta2 zero", {15'd0, ta2_v}, 16'd0);
    check("R12 released after read", {15'd0, end_oe}, 16'd0);
    wr(5'd22, 16'hBEEF); rdr(5'd22, d); check("R2 reg22", d, 16'hBEEF);
    check("R5 msb-first data", {15'd0, d[15]}, 16'd1);
  endtask

  task automatic t_foreign;
    logic [15:0] d;
    frame(32, 2'b10, 5'h04, 5'd4, 16'h0, d);
    check("R3 no drive foreign read", {15'd0, any_oe}, 16'd0);
    frame(32, 2'b01, 5'h13, 5'd4, 16'h1111, d);
    rdr(5'd4, d); check("R3 foreign write ignored", d, 16'h05E1);
  endtask

  task automatic t_short;
    logic [15:0] d;
    frame(31, 2'b01, MY, 5'd4, 16'h2222, d);
    rdr(5'd4, d); check("R4 short preamble ignored", d, 16'h05E1);
  endtask

  task automatic t_pdn;
    logic [15:0] d;
    wr(5'd0, 16'h3900); check("R6 pwr_down set", {15'd0, pwr_down}, 16'd1);
    rdr(5'd0, d); check("R6 read in power-down", d, 16'h3900);
    wr(5'd0, 16'h3100); check("R6 pwr_down clear", {15'd0, pwr_down}, 16'd0);
  endtask

  task automatic t_apd;
    logic [15:0] d;
    wr(5'd16, 16'h0000); check("R7 apd off", {15'd0, auto_pd_en}, 16'd0);
    rdr(5'd16, d); check("R7 reg16", d, 16'h0000);
    wr(5'd16, 16'h0010); check("R7 apd on", {15'd0, auto_pd_en}, 16'd1);
  endtask

  task automatic t_srst;
    logic [15:0] d;
    wr(5'd0, 16'h3900); wr(5'd4, 16'h0A0A); wr(5'd16, 16'h0000);
    wr(5'd0, 16'h8000);
    check("R8 pwr_down default", {15'd0, pwr_down}, 16'd0);
    check("R8 apd default", {15'd0, auto_pd_en}, 16'd1);
    rdr(5'd0, d); check("R8 reg0 self-clear", d, 16'h3100);
    rdr(5'd4, d); check("R8 reg4 default", d, 16'h01E1);
  endtask

  task automatic t_unimpl;
    logic [15:0] d;
    wr(5'd7, 16'hFFFF); rdr(5'd7, d); check("R9 reg7", d, 16'h0000);
    rdr(5'd30, d); check("R9 reg30", d, 16'h0000);
    rdr(5'd4, d); check("R9 no side effect", d, 16'h01E1);
  endtask

  task automatic t_ro;
    logic [15:0] d;
    rdr(5'd2, d); check("R11 id1", d, 16'h0181);
    wr(5'd2, 16'h0000); rdr(5'd2, d); check("R11 id1 write ignored", d, 16'h0181);
    rdr(5'd3, d); check("R11 id2", d, 16'hB8A0);
    rdr(5'd1, d); check("R11 status link up", d, 16'h784D);
    link_up = 1'b0;
    rdr(5'd1, d); check("R11 status link down", d, 16'h7849);
    rdr(5'd5, d); check("R11 partner ability", d, 16'h45E1);
  endtask

  task automatic t_irq;
    logic [15:0] d;
    pulse(4'b0010); check("R10 irq raised", {15'd0, irq}, 16'd1);
    rdr(5'd21, d); check("R10 pending read", d, 16'h0002);
    check("R10 irq cleared by read", {15'd0, irq}, 16'd0);
    wr(5'd21, 16'h02FF);
    pulse(4'b0010); check("R10 masked event", {15'd0, irq}, 16'd0);
    pulse(4'b0001); check("R10 unmasked event", {15'd0, irq}, 16'd1);
    rdr(5'd21, d); check("R10 mask and pending", d, 16'h0203);
    rdr(5'd21, d); check("R10 pending cleared", d, 16'h0200);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset; t_rw; t_foreign; t_short; t_pdn; t_apd;
    t_srst; t_unimpl; t_ro; t_irq;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog act=running exp=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule